// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the byte-wide programming port of an eight-line priority interrupt controller. It has a single address bit. Writes to the even address carry one of three things: the word that starts initialisation, a control word that sets read and mode options, or an operation command. The operation commands cover the end-of-interrupt variants and priority rotation. Writes to the odd address serve two purposes. While initialisation is in progress they supply the later set-up words. Once set-up is finished they load the interrupt mask.

The block turns each command into a single-cycle strobe for the priority resolver, which sits next to it. It also keeps the configuration that the resolver and the vector logic read: the vector base, the auto end-of-interrupt flag, the nested mode flag and the rotate-on-auto-EOI flag. The resolver supplies the request and in-service bytes, together with its current winning line. Reads return one of these bytes or the mask. After a poll command, the next read returns the winning line and tells the resolver to clear that line.

Top module: `pic_regif`

## Requirements
- R1: An even-address write with bit 4 set restarts set-up from any state. On the next cycle `init_step` is 1, `init_pulse` is high for one cycle, `need_mode_word` equals bit 0 of the data, and every other register and mode flag is zero: mask, vector base, nested mode, auto-EOI, rotate-on-auto-EOI, special mask, poll and read select.
- R2: When `init_step` is 1, an odd-address write stores data bits 7:3 in `vec_base` and sets `init_step` to 2. Data bits 2:0 are ignored.
- R3: When `init_step` is 2, an odd-address write moves to step 3 if `need_mode_word` is set, and to step 0 otherwise. When `init_step` is 3, an odd-address write sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, then returns to step 0.
- R4: When `init_step` is 0, an odd-address write loads `mask_out` with the data and raises `mask_load` for one cycle. An odd-address write during steps 1 to 3 leaves the mask unchanged.
- R5: An even-address write with bit 4 clear and bit 3 set is a control word. When bit 1 is set, bit 0 selects the even-address read: 1 returns `isr_in` and 0 returns `irr_in`. When bit 6 is set, bit 5 loads `special_mask`. When bit 2 is set, poll is armed.
- R6: An even-address write with bits 4 and 3 clear is a command, with the command code in bits 7:5. Code 0 clears `rot_auto_eoi` and code 4 sets it. Code 2 does nothing. Codes 1, 3, 5, 6 and 7 raise `op_valid` for one cycle on the next clock. In that cycle `op_kind` equals the code (1 non-specific EOI, 3 specific EOI, 5 rotating EOI, 6 set priority, 7 rotating specific EOI) and `op_line` equals data bits 2:0.
- R7: When poll is armed, a read at either address returns the resolver's line (`res_line`, zero-extended) if `res_valid` is set, or 7 if it is not. Poll then disarms. When a line was returned, `poll_clr` is high for one cycle on the next clock with `poll_line` equal to that line.
- R8: When poll is not armed, an odd-address read returns the mask, and an even-address read returns the request or in-service byte according to the read select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| irr_in | input | 8 | Request byte from the resolver |
| isr_in | input | 8 | In-service byte from the resolver |
| res_valid | input | 1 | Resolver has a winning line |
| res_line | input | 3 | Resolver's winning line |
| init_pulse | output | 1 | Set-up restart; the resolver clears its state and drops its output |
| mask_out | output | 8 | Interrupt mask |
| mask_load | output | 1 | Mask was written; the resolver re-evaluates |
| op_valid | output | 1 | Command strobe |
| op_kind | output | 3 | Command code |
| op_line | output | 3 | Line named by the command |
| poll_clr | output | 1 | Clear the request and in-service bits of the polled line |
| poll_line | output | 3 | Polled line |
| vec_base | output | 5 | Vector base, upper five bits |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| nested_mode | output | 1 | Special fully nested mode |
| need_mode_word | output | 1 | The fourth set-up word is expected |
| rot_auto_eoi | output | 1 | Rotate on auto end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| init_step | output | 2 | Set-up step (0 means normal) |

## Verification
The bench sweeps all 32 vector bases and all 256 mask values, every command code combined with every line number, and polling of each line. The restart case matters most. A restart issued partway through set-up must return the step to 1 and clear the poll and read-select state. A design that only started set-up from step 0 would leave the sequence stalled mid-way, and a design that kept the read select would return the in-service byte where the request byte is expected. Two further checks target the shared odd address. An odd write during set-up must not leak into the mask, and a poll must be strictly one-shot, so the read after it must return the mask again rather than a second poll result.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_BASE   = 2'd1,
        ST_SKIP   = 2'd2,
        ST_MODE   = 2'd3
    } init_step_e;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_EOI_ANY      = 3'd1,
        OP_EOI_LINE     = 3'd3,
        OP_EOI_ROTATE   = 3'd5,
        OP_SET_PRIO     = 3'd6,
        OP_EOI_ROT_LINE = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic nested;
        logic auto_eoi;
        logic need_mode;
    } mode_t;

    function automatic logic is_init_word(input logic a, input logic [BYTE_W-1:0] d);
        return !a && d[4];
    endfunction

    function automatic logic is_ctrl_word(input logic a, input logic [BYTE_W-1:0] d);
        return !a && !d[4] && d[3];
    endfunction

    function automatic logic is_cmd_word(input logic a, input logic [BYTE_W-1:0] d);
        return !a && !d[4] && !d[3];
    endfunction

    function automatic op_kind_e cmd_to_op(input logic [2:0] c);
        case (c)
            3'd1:    return OP_EOI_ANY;
            3'd3:    return OP_EOI_LINE;
            3'd5:    return OP_EOI_ROTATE;
            3'd6:    return OP_SET_PRIO;
            3'd7:    return OP_EOI_ROT_LINE;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_regif_pkg::*;
#(
    parameter int BASE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [BYTE_W-1:0]   wdata,
    output init_step_e          step,
    output logic [BASE_W-1:0]   base,
    output mode_t               mode,
    output logic [BYTE_W-1:0]   mask,
    output logic                mask_load,
    output logic                init_pulse
);

    logic init_hit;
    logic odd_wr;

    assign init_hit = wr_en && is_init_word(wr_addr, wdata);
    assign odd_wr   = wr_en && wr_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            step       <= ST_NORMAL;
            base       <= '0;
            mode       <= '0;
            mask       <= '0;
            mask_load  <= 1'b0;
            init_pulse <= 1'b0;
        end else begin
            mask_load  <= 1'b0;
            init_pulse <= 1'b0;
            if (init_hit) begin
                step           <= ST_BASE;
                base           <= '0;
                mode.nested    <= 1'b0;
                mode.auto_eoi  <= 1'b0;
                mode.need_mode <= wdata[0];
                mask           <= '0;
                init_pulse     <= 1'b1;
            end else if (odd_wr) begin
                case (step)
                    ST_NORMAL: begin
                        mask      <= wdata;
                        mask_load <= 1'b1;
                    end
                    ST_BASE: begin
                        base <= wdata[BYTE_W-1 -: BASE_W];
                        step <= ST_SKIP;
                    end
                    ST_SKIP: begin
                        step <= mode.need_mode ? ST_MODE : ST_NORMAL;
                    end
                    default: begin
                        mode.nested   <= wdata[4];
                        mode.auto_eoi <= wdata[1];
                        step          <= ST_NORMAL;
                    end
                endcase
            end
        end
    end

    // R1: restart lands in the base step with a strobe
    a_r1_restart_step: assert property (@(posedge clk) disable iff (rst)
        init_hit |=> (step == ST_BASE && init_pulse && mask == '0));

    // R4: mask untouched by odd writes during set-up
    a_r4_mask_guard: assert property (@(posedge clk) disable iff (rst)
        (odd_wr && step != ST_NORMAL) |=> $stable(mask));

    // R3: mode flags change only on the fourth word or a restart
    a_r3_mode_guard: assert property (@(posedge clk) disable iff (rst)
        (!init_hit && !(odd_wr && step == ST_MODE)) |=> $stable(mode));

    // R2: the base step always advances to the skip step
    a_r2_base_advance: assert property (@(posedge clk) disable iff (rst)
        (odd_wr && !init_hit && step == ST_BASE) |=> step == ST_SKIP);

endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
    import pic_regif_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                rd_en,
    output logic                poll_armed,
    output logic                read_isr,
    output logic                smm,
    output logic                rot_aeoi,
    output logic                op_valid,
    output op_kind_e            op_kind,
    output logic [LINE_W-1:0]   op_line
);

    logic       init_hit;
    logic       ctrl_hit;
    logic       cmd_hit;
    logic [2:0] code;

    assign init_hit = wr_en && is_init_word(wr_addr, wdata);
    assign ctrl_hit = wr_en && is_ctrl_word(wr_addr, wdata);
    assign cmd_hit  = wr_en && is_cmd_word(wr_addr, wdata);
    assign code     = wdata[7:5];

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_armed <= 1'b0;
            read_isr   <= 1'b0;
            smm        <= 1'b0;
            rot_aeoi   <= 1'b0;
            op_valid   <= 1'b0;
            op_kind    <= OP_NONE;
            op_line    <= '0;
        end else begin
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            if (rd_en) begin
                poll_armed <= 1'b0;
            end
            if (init_hit) begin
                poll_armed <= 1'b0;
                read_isr   <= 1'b0;
                smm        <= 1'b0;
                rot_aeoi   <= 1'b0;
            end else if (ctrl_hit) begin
                if (wdata[2]) poll_armed <= 1'b1;
                if (wdata[1]) read_isr   <= wdata[0];
                if (wdata[6]) smm        <= wdata[5];
            end else if (cmd_hit) begin
                case (code)
                    3'd0: rot_aeoi <= 1'b0;
                    3'd4: rot_aeoi <= 1'b1;
                    3'd2: ;
                    default: begin
                        op_valid <= 1'b1;
                        op_kind  <= cmd_to_op(code);
                        op_line  <= wdata[LINE_W-1:0];
                    end
                endcase
            end
        end
    end

    // R6: a strobe always carries a real command code
    a_r6_kind_valid: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> op_kind != OP_NONE);

    // R6: strobe lasts one cycle without a new command
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !cmd_hit) |=> !op_valid);

    // R7: a read without a write disarms poll
    a_r7_poll_oneshot: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> !poll_armed);

    // R1: restart clears read options and command strobe
    a_r1_restart_clears: assert property (@(posedge clk) disable iff (rst)
        init_hit |=> (!poll_armed && !read_isr && !smm && !rot_aeoi && !op_valid));

endmodule

// File: rtl/pic_read_path.sv
module pic_read_path
    import pic_regif_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                rd_addr,
    input  logic                poll_armed,
    input  logic                read_isr,
    input  logic [BYTE_W-1:0]   irr,
    input  logic [BYTE_W-1:0]   isr,
    input  logic [BYTE_W-1:0]   mask,
    input  logic                res_valid,
    input  logic [LINE_W-1:0]   res_line,
    output logic [BYTE_W-1:0]   rdata,
    output logic                poll_clr,
    output logic [LINE_W-1:0]   poll_line
);

    localparam logic [BYTE_W-1:0] SPURIOUS = BYTE_W'((1 << LINE_W) - 1);

    always_comb begin
        if (poll_armed) begin
            rdata = res_valid ? BYTE_W'(res_line) : SPURIOUS;
        end else if (rd_addr) begin
            rdata = mask;
        end else begin
            rdata = read_isr ? isr : irr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_clr  <= 1'b0;
            poll_line <= '0;
        end else begin
            poll_clr <= rd_en && poll_armed && res_valid;
            if (rd_en && poll_armed && res_valid) begin
                poll_line <= res_line;
            end
        end
    end

    // R7: a clear strobe only follows a successful poll read
    a_r7_clear_source: assert property (@(posedge clk) disable iff (rst)
        poll_clr |-> $past(rd_en && poll_armed && res_valid));

    // R8: outside poll, odd reads show the mask
    a_r8_mask_read: assert property (@(posedge clk) disable iff (rst)
        (!poll_armed && rd_addr) |-> rdata == mask);

endmodule

// File: rtl/pic_regif.sv
module pic_regif
    import pic_regif_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int BASE_W   = BYTE_W - LINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [7:0]         irr_in,
    input  logic [7:0]         isr_in,
    input  logic               res_valid,
    input  logic [LINE_W-1:0]  res_line,
    output logic               init_pulse,
    output logic [7:0]         mask_out,
    output logic               mask_load,
    output logic               op_valid,
    output logic [2:0]         op_kind,
    output logic [LINE_W-1:0]  op_line,
    output logic               poll_clr,
    output logic [LINE_W-1:0]  poll_line,
    output logic [BASE_W-1:0]  vec_base,
    output logic               auto_eoi,
    output logic               nested_mode,
    output logic               need_mode_word,
    output logic               rot_auto_eoi,
    output logic               special_mask,
    output logic [1:0]         init_step
);

    init_step_e step_w;
    mode_t      mode_w;
    op_kind_e   kind_w;
    logic       poll_armed_w;
    logic       read_isr_w;

    pic_init_fsm #(.BASE_W(BASE_W)) u_init (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (addr),
        .wdata      (wdata),
        .step       (step_w),
        .base       (vec_base),
        .mode       (mode_w),
        .mask       (mask_out),
        .mask_load  (mask_load),
        .init_pulse (init_pulse)
    );

    pic_ocw_decode #(.LINE_W(LINE_W)) u_ocw (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (addr),
        .wdata      (wdata),
        .rd_en      (rd_en),
        .poll_armed (poll_armed_w),
        .read_isr   (read_isr_w),
        .smm        (special_mask),
        .rot_aeoi   (rot_auto_eoi),
        .op_valid   (op_valid),
        .op_kind    (kind_w),
        .op_line    (op_line)
    );

    pic_read_path #(.LINE_W(LINE_W)) u_read (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_addr    (addr),
        .poll_armed (poll_armed_w),
        .read_isr   (read_isr_w),
        .irr        (irr_in),
        .isr        (isr_in),
        .mask       (mask_out),
        .res_valid  (res_valid),
        .res_line   (res_line),
        .rdata      (rdata),
        .poll_clr   (poll_clr),
        .poll_line  (poll_line)
    );

    assign init_step      = step_w;
    assign op_kind        = kind_w;
    assign auto_eoi       = mode_w.auto_eoi;
    assign nested_mode    = mode_w.nested;
    assign need_mode_word = mode_w.need_mode;

endmodule

// File: tb/pic_regif_tb.sv
`timescale 1ns/1ps
module pic_regif_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irr_in = 8'h5A;
    logic [7:0] isr_in = 8'hC3;
    logic       res_valid = 1'b0;
    logic [2:0] res_line = 3'd0;
    logic       init_pulse, mask_load, op_valid, poll_clr;
    logic       auto_eoi, nested_mode, need_mode_word, rot_auto_eoi, special_mask;
    logic [7:0] mask_out;
    logic [2:0] op_kind, op_line, poll_line;
    logic [4:0] vec_base;
    logic [1:0] init_step;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    pic_regif u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .res_valid(res_valid), .res_line(res_line), .init_pulse(init_pulse),
        .mask_out(mask_out), .mask_load(mask_load), .op_valid(op_valid),
        .op_kind(op_kind), .op_line(op_line), .poll_clr(poll_clr),
        .poll_line(poll_line), .vec_base(vec_base), .auto_eoi(auto_eoi),
        .nested_mode(nested_mode), .need_mode_word(need_mode_word),
        .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask),
        .init_step(init_step)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int exp_rot;
        int exp_kind;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        chk("reset R1 step", init_step, 0);
        chk("reset R1 base", vec_base, 0);
        chk("reset R3 modes", {nested_mode, auto_eoi, rot_auto_eoi, special_mask}, 0);
        rd(1'b1, v); chk("reset R8 mask read", v, 0);
        rd(1'b0, v); chk("reset R8 irr read", v, 8'h5A);

        // full set-up with fourth word
        wr(1'b0, 8'h11);
        chk("R1 step", init_step, 1);
        chk("R1 pulse", init_pulse, 1);
        chk("R1 need word", need_mode_word, 1);
        wr(1'b1, 8'hA8);
        chk("R2 base", vec_base, 21);
        chk("R2 step", init_step, 2);
        wr(1'b1, 8'hFF);
        chk("R3 step to mode", init_step, 3);
        chk("R4 mask untouched in setup", mask_out, 0);
        chk("R4 no load in setup", mask_load, 0);
        wr(1'b1, 8'h12);
        chk("R3 nested", nested_mode, 1);
        chk("R3 auto eoi", auto_eoi, 1);
        chk("R3 back to normal", init_step, 0);

        // vector base sweep, no fourth word
        for (int b = 0; b < 32; b++) begin
            wr(1'b0, 8'h10);
            chk("R1 need word clear", need_mode_word, 0);
            chk("R1 restart clears nested", nested_mode, 0);
            wr(1'b1, 8'((b << 3) | 5));
            chk("R2 base sweep", vec_base, b);
            wr(1'b1, 8'h00);
            chk("R3 skip to normal", init_step, 0);
        end

        // mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            chk("R4 mask value", mask_out, m);
            chk("R4 mask strobe", mask_load, 1);
            rd(1'b1, v);
            chk("R8 mask readback", v, m);
        end

        // read select and special mask
        rd(1'b0, v); chk("R8 irr default", v, 8'h5A);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R5 isr select", v, 8'hC3);
        wr(1'b0, 8'h09); rd(1'b0, v); chk("R5 select held", v, 8'hC3);
        wr(1'b0, 8'h0A); rd(1'b0, v); chk("R5 irr select", v, 8'h5A);
        wr(1'b0, 8'h68); chk("R5 smm set", special_mask, 1);
        wr(1'b0, 8'h28); chk("R5 smm held", special_mask, 1);
        wr(1'b0, 8'h48); chk("R5 smm clear", special_mask, 0);

        // command sweep
        exp_rot = 0;
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 8; l++) begin
                wr(1'b0, 8'((c << 5) | l));
                if (c == 0) exp_rot = 0;
                if (c == 4) exp_rot = 1;
                exp_kind = (c == 0 || c == 2 || c == 4) ? 0 : c;
                chk("R6 strobe", op_valid, exp_kind != 0 ? 1 : 0);
                chk("R6 kind", op_kind, exp_kind);
                if (exp_kind != 0) chk("R6 line", op_line, l);
                chk("R6 rotate flag", rot_auto_eoi, exp_rot);
                chk("R6 mask kept", mask_out, 255);
            end
        end

        // poll with a winner on each line
        res_valid = 1'b1;
        for (int l = 0; l < 8; l++) begin
            res_line = 3'(l);
            wr(1'b0, 8'h0C);
            rd(1'b1, v);
            chk("R7 poll value", v, l);
            chk("R7 clear strobe", poll_clr, 1);
            chk("R7 clear line", poll_line, l);
            rd(1'b1, v);
            chk("R7 one shot", v, 255);
            chk("R7 no second clear", poll_clr, 0);
        end
        res_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R7 spurious", v, 7);
        chk("R7 spurious no clear", poll_clr, 0);
        rd(1'b0, v);
        chk("R8 after poll irr", v, 8'h5A);

        // restart mid sequence
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h6C);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h08);
        chk("R1 mid step", init_step, 2);
        wr(1'b0, 8'h10);
        chk("R1 restart mid", init_step, 1);
        chk("R1 restart pulse", init_pulse, 1);
        chk("R1 restart mask", mask_out, 0);
        chk("R1 restart base", vec_base, 0);
        chk("R1 restart flags", {rot_auto_eoi, special_mask}, 0);
        rd(1'b0, v);
        chk("R1 restart read state", v, 8'h5A);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule